// File: doc/BRIEF.md
# Per-Area External Bus Cycle Controller

This block runs basic external bus cycles on behalf of a CPU. The top bits of the request address pick one of eight equal address areas. Each area has its own settings, taken from static configuration inputs:

- a data width of 8 or 16 bits;
- a 2-state or 3-state access;
- a count of 0 to 3 programmed wait states.

The controller steps through the bus states one clock each. It drives a chip select for each area, an address strobe, a read strobe and separate high-byte and low-byte write strobes. It also places write data on the upper or lower byte lane of the 16-bit external data bus.

A 3-state cycle can be stretched further by an active-low wait input, once the programmed waits are used up. A word access to an 8-bit area is carried out as two byte cycles, even address first. An optional idle clock separates a read from a following write, or from a following read of another area.

The CPU side is a one-clock request, accepted while `ready` is high. Completion is a one-clock `done` pulse that carries the read data.

Top module: `ebc_bus_ctrl`

## Requirements
- R1: The area index is the top log2(NUM_AREAS) bits of the address. During every access state (T1, T2, wait, T3), exactly that area's `cs_n` bit is low and `bus_addr` shows the cycle address. Outside access states all `cs_n` bits are high.
- R2: An area with `cfg_three` bit 0 runs exactly two access clocks (T1, T2). Its programmed wait count and the wait pin have no effect on it.
- R3: An area with `cfg_three` bit 1 and programmed wait count N runs T1, T2, N wait clocks and T3, which is 3+N access clocks. N is `cfg_wait[2a+1:2a]` for area a. `as_n` is low for all of these clocks.
- R4: When `cfg_pin_wait_en` is 1 in a 3-state area, `wait_n` is sampled in the last state that has no programmed wait left (T2 when N=0, otherwise the last programmed wait). Each such state seen with `wait_n` low adds one more wait clock. With `cfg_pin_wait_en` at 0, `wait_n` is ignored.
- R5: In a 16-bit area (`cfg_wide` bit 1), a byte access at an even address uses the upper lane `bus_dout[15:8]` and `hwr_n`. At an odd address it uses the lower lane `bus_dout[7:0]` and `lwr_n`. A word access uses both lanes, with `req_wdata[15:8]` on the upper lane. Write bytes appear on both lanes, and the strobe selects the lane.
- R6: In an 8-bit area only the upper lane and `hwr_n` are used, and `lwr_n` stays high. A word access becomes two byte cycles, first at the even address carrying `req_wdata[15:8]`, then at the odd address carrying `req_wdata[7:0]`. A word read returns the even byte in `rdata[15:8]`.
- R7: `rd_n` is low in every access state of a read. For a write, `bus_oe` is high in every access state, and the selected write strobe is low from T2 through the last state. `rd_n` and a write strobe are never low together.
- R8: With `cfg_idle_en` at 1, a read followed by a write, or by a read of a different area, gets one idle clock with all strobes high before T1. A read of the same area gets none. With `cfg_idle_en` at 0 no idle clock is inserted.
- R9: `ready` is high exactly when no access is in progress. `done` is a one-clock pulse in the clock after the last access state, and `rdata` is valid with it. A byte read returns its byte in `rdata[7:0]` with `rdata[15:8]` zero. On a 16-bit area the byte comes from the lane selected by the address.
- R10: After reset, `ready` is 1, `done` is 0, all `cs_n`, `as_n`, `rd_n`, `hwr_n` and `lwr_n` are high, and `bus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus state per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | NUM_AREAS | Per-area width: 1 = 16-bit, 0 = 8-bit |
| cfg_three | input | NUM_AREAS | Per-area access: 1 = 3-state, 0 = 2-state |
| cfg_wait | input | NUM_AREAS*WAIT_W | Per-area programmed wait count |
| cfg_pin_wait_en | input | 1 | Enables stretching by `wait_n` |
| cfg_idle_en | input | 1 | Enables the idle clock after reads |
| req | input | 1 | Access request, taken while `ready` is high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_addr | input | ADDR_W | Byte address (even for words) |
| req_wdata | input | 2*BYTE_W | Write data; byte writes use the low byte |
| ready | output | 1 | Controller idle |
| done | output | 1 | Access finished |
| rdata | output | 2*BYTE_W | Read result |
| bus_addr | output | ADDR_W | External address |
| cs_n | output | NUM_AREAS | Area chip selects, active low |
| as_n | output | 1 | Address strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| hwr_n | output | 1 | Upper-lane write strobe, active low |
| lwr_n | output | 1 | Lower-lane write strobe, active low |
| bus_dout | output | 2*BYTE_W | External write data |
| bus_oe | output | 1 | Write data drive enable |
| bus_din | input | 2*BYTE_W | External read data |
| wait_n | input | 1 | External wait request, active low |

## Verification
The bench builds the controller with ADDR_W=20, which gives 128-kbyte areas decoded from bits 19:17, and keeps eight areas and the wait pin logic. Its area settings mix both widths and both state counts. Programmed waits of 0 to 3 are used, including a nonzero count on a 2-state area, so the cycle-length rules, pin waits after programmed waits, split word cycles and every idle-clock case come within reach. The external data bus returns a pattern derived from the address, so each read checks which lane and which half fed each result byte.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_GAP  = 3'd1,
      ST_T1   = 3'd2,
      ST_T2   = 3'd3,
      ST_TW   = 3'd4,
      ST_T3   = 3'd5
   } bus_state_e;

   function automatic logic in_access(bus_state_e s);
      return (s == ST_T1) || (s == ST_T2) || (s == ST_TW) || (s == ST_T3);
   endfunction

   function automatic logic in_strobe(bus_state_e s);
      return (s == ST_T2) || (s == ST_TW) || (s == ST_T3);
   endfunction
endpackage

// File: rtl/ebc_area_decode.sv
module ebc_area_decode #(
   parameter int ADDR_W    = 24,
   parameter int NUM_AREAS = 8,
   parameter int WAIT_W    = 2,
   localparam int AREA_W   = $clog2(NUM_AREAS)
) (
   input  logic [ADDR_W-1:0]           addr,
   input  logic [NUM_AREAS-1:0]        cfg_wide,
   input  logic [NUM_AREAS-1:0]        cfg_three,
   input  logic [NUM_AREAS*WAIT_W-1:0] cfg_wait,
   output logic [AREA_W-1:0]           area,
   output logic                        wide,
   output logic                        three,
   output logic [WAIT_W-1:0]           waits
);
   assign area  = addr[ADDR_W-1 -: AREA_W];
   assign wide  = cfg_wide[area];
   assign three = cfg_three[area];
   assign waits = cfg_wait[area*WAIT_W +: WAIT_W];
endmodule

// File: rtl/ebc_wait_timer.sv
module ebc_wait_timer #(
   parameter int WAIT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WAIT_W-1:0] load_val,
   input  logic              dec,
   output logic              zero
);
   logic [WAIT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (dec && (cnt != '0))
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/ebc_lane_steer.sv
module ebc_lane_steer #(
   parameter int BYTE_W  = 8,
   localparam int BUS_W  = 2 * BYTE_W
) (
   input  logic              wide,
   input  logic              word_cyc,
   input  logic              a0,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic [BUS_W-1:0]  word_in,
   input  logic [BUS_W-1:0]  din,
   output logic              up_en,
   output logic              lo_en,
   output logic [BUS_W-1:0]  dout,
   output logic [BYTE_W-1:0] rd_byte
);
   assign up_en   = !wide || word_cyc || !a0;
   assign lo_en   = wide && (word_cyc || a0);
   assign dout    = word_cyc ? word_in : {byte_in, byte_in};
   assign rd_byte = (wide && !word_cyc && a0) ? din[BYTE_W-1:0] : din[BUS_W-1:BYTE_W];
endmodule

// File: rtl/ebc_bus_ctrl.sv
module ebc_bus_ctrl
   import ebc_pkg::*;
#(
   parameter int ADDR_W       = 24,
   parameter int NUM_AREAS    = 8,
   parameter int BYTE_W       = 8,
   parameter int WAIT_W       = 2,
   parameter bit HAS_WAIT_PIN = 1'b1,
   localparam int AREA_W      = $clog2(NUM_AREAS),
   localparam int BUS_W       = 2 * BYTE_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_AREAS-1:0]        cfg_wide,
   input  logic [NUM_AREAS-1:0]        cfg_three,
   input  logic [NUM_AREAS*WAIT_W-1:0] cfg_wait,
   input  logic                        cfg_pin_wait_en,
   input  logic                        cfg_idle_en,
   input  logic                        req,
   input  logic                        req_wr,
   input  logic                        req_word,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [BUS_W-1:0]            req_wdata,
   output logic                        ready,
   output logic                        done,
   output logic [BUS_W-1:0]            rdata,
   output logic [ADDR_W-1:0]           bus_addr,
   output logic [NUM_AREAS-1:0]        cs_n,
   output logic                        as_n,
   output logic                        rd_n,
   output logic                        hwr_n,
   output logic                        lwr_n,
   output logic [BUS_W-1:0]            bus_dout,
   output logic                        bus_oe,
   input  logic [BUS_W-1:0]            bus_din,
   input  logic                        wait_n
);
   // elaboration-time parameter checks
   if (NUM_AREAS < 2 || (1 << AREA_W) != NUM_AREAS) begin : g_bad_areas
      initial $error("NUM_AREAS must be a power of two of at least 2");
   end
   if (ADDR_W <= AREA_W + 1) begin : g_bad_addr
      initial $error("ADDR_W too small for the area count");
   end
   if (BYTE_W < 1 || WAIT_W < 1) begin : g_bad_width
      initial $error("BYTE_W and WAIT_W must be positive");
   end

   bus_state_e        st;
   logic [AREA_W-1:0] cur_area, prev_area;
   logic              cur_wide, cur_three, cur_wr, cur_word, cur_split, half;
   logic [WAIT_W-1:0] cur_waits;
   logic [ADDR_W-1:0] cur_addr;
   logic [BUS_W-1:0]  cur_wdata, rdata_q;
   logic              prev_rd, done_q;

   logic [AREA_W-1:0] dec_area;
   logic              dec_wide, dec_three;
   logic [WAIT_W-1:0] dec_waits;

   ebc_area_decode #(
      .ADDR_W(ADDR_W), .NUM_AREAS(NUM_AREAS), .WAIT_W(WAIT_W)
   ) decode_i (
      .addr(req_addr), .cfg_wide(cfg_wide), .cfg_three(cfg_three),
      .cfg_wait(cfg_wait), .area(dec_area), .wide(dec_wide),
      .three(dec_three), .waits(dec_waits)
   );

   logic wt_zero;
   ebc_wait_timer #(.WAIT_W(WAIT_W)) timer_i (
      .clk(clk), .rst_n(rst_n),
      .load(st == ST_T1), .load_val(cur_waits),
      .dec(cur_three && (st == ST_T2 || st == ST_TW)),
      .zero(wt_zero)
   );

   logic pin_low;
   if (HAS_WAIT_PIN) begin : g_pin
      assign pin_low = cfg_pin_wait_en & ~wait_n;
   end else begin : g_nopin
      assign pin_low = 1'b0;
   end

   logic              cyc_a0, cyc_word, up_en, lo_en;
   logic [BYTE_W-1:0] byte_in, rd_byte;
   logic [BUS_W-1:0]  lane_dout;

   assign cyc_a0   = cur_split ? half : cur_addr[0];
   assign cyc_word = cur_word && cur_wide;
   assign byte_in  = (cur_split && !half) ? cur_wdata[BUS_W-1:BYTE_W]
                                          : cur_wdata[BYTE_W-1:0];

   ebc_lane_steer #(.BYTE_W(BYTE_W)) lanes_i (
      .wide(cur_wide), .word_cyc(cyc_word), .a0(cyc_a0),
      .byte_in(byte_in), .word_in(cur_wdata), .din(bus_din),
      .up_en(up_en), .lo_en(lo_en), .dout(lane_dout), .rd_byte(rd_byte)
   );

   logic last_st, need_gap;
   assign last_st  = (st == ST_T3) || (st == ST_T2 && !cur_three);
   assign need_gap = cfg_idle_en && prev_rd && (req_wr || dec_area != prev_area);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cur_area  <= '0;
         prev_area <= '0;
         cur_wide  <= 1'b0;
         cur_three <= 1'b0;
         cur_waits <= '0;
         cur_wr    <= 1'b0;
         cur_word  <= 1'b0;
         cur_split <= 1'b0;
         half      <= 1'b0;
         cur_addr  <= '0;
         cur_wdata <= '0;
         prev_rd   <= 1'b0;
         done_q    <= 1'b0;
         rdata_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (last_st && !cur_wr) begin
            if (cyc_word)
               rdata_q <= bus_din;
            else if (cur_split && !half)
               rdata_q[BUS_W-1:BYTE_W] <= rd_byte;
            else if (cur_split)
               rdata_q[BYTE_W-1:0] <= rd_byte;
            else
               rdata_q <= {{BYTE_W{1'b0}}, rd_byte};
         end
         case (st)
            ST_IDLE: if (req) begin
               cur_area  <= dec_area;
               cur_wide  <= dec_wide;
               cur_three <= dec_three;
               cur_waits <= dec_waits;
               cur_wr    <= req_wr;
               cur_word  <= req_word;
               cur_split <= req_word && !dec_wide;
               cur_addr  <= req_addr;
               cur_wdata <= req_wdata;
               half      <= 1'b0;
               st        <= need_gap ? ST_GAP : ST_T1;
            end
            ST_GAP: st <= ST_T1;
            ST_T1:  st <= ST_T2;
            ST_T2, ST_TW: begin
               if (!cur_three)
                  st <= ST_T3;
               else if (!wt_zero || pin_low)
                  st <= ST_TW;
               else
                  st <= ST_T3;
            end
            default: st <= ST_IDLE;
         endcase
         if (last_st) begin
            if (cur_split && !half) begin
               half <= 1'b1;
               st   <= ST_T1;
            end else begin
               st        <= ST_IDLE;
               done_q    <= 1'b1;
               prev_rd   <= !cur_wr;
               prev_area <= cur_area;
            end
         end
      end
   end

   logic active, strobe_ph;
   assign active    = in_access(st);
   assign strobe_ph = in_strobe(st);

   for (genvar g = 0; g < NUM_AREAS; g++) begin : g_cs
      assign cs_n[g] = !(active && cur_area == AREA_W'(g));
   end

   assign as_n     = !active;
   assign rd_n     = !(active && !cur_wr);
   assign hwr_n    = !(strobe_ph && cur_wr && up_en);
   assign lwr_n    = !(strobe_ph && cur_wr && lo_en);
   assign bus_oe   = active && cur_wr;
   assign bus_dout = lane_dout;
   assign bus_addr = {cur_addr[ADDR_W-1:1], cyc_a0};
   assign ready    = (st == ST_IDLE);
   assign done     = done_q;
   assign rdata    = rdata_q;
endmodule

// File: rtl/ebc_bus_ctrl_chk.sv
module ebc_bus_ctrl_chk
   import ebc_pkg::*;
#(
   parameter int NUM_AREAS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input bus_state_e           st,
   input logic [NUM_AREAS-1:0] cs_n,
   input logic                 as_n,
   input logic                 rd_n,
   input logic                 hwr_n,
   input logic                 lwr_n,
   input logic                 ready,
   input logic                 done,
   input logic                 cur_wide,
   input logic                 cur_three,
   input logic                 wt_zero,
   input logic                 pin_low
);
   assert_cs_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !as_n |-> ($countones(~cs_n) == 1));

   assert_cs_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      as_n |-> (cs_n == '1));

   assert_two_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_T2 && !cur_three) |=> (st != ST_TW && st != ST_T3));

   assert_t1_then_t2_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_T1) |=> (st == ST_T2));

   assert_pin_extends_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TW && wt_zero && pin_low) |=> (st == ST_TW));

   assert_narrow_low_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_wide |-> lwr_n);

   assert_rd_wr_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && (!hwr_n || !lwr_n)));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ready && as_n));
endmodule

bind ebc_bus_ctrl ebc_bus_ctrl_chk #(.NUM_AREAS(NUM_AREAS)) chk_i (
   .clk(clk), .rst_n(rst_n), .st(st), .cs_n(cs_n), .as_n(as_n),
   .rd_n(rd_n), .hwr_n(hwr_n), .lwr_n(lwr_n), .ready(ready), .done(done),
   .cur_wide(cur_wide), .cur_three(cur_three), .wt_zero(wt_zero),
   .pin_low(pin_low)
);

// File: tb/ebc_bus_ctrl_tb_top.sv
module ebc_bus_ctrl_tb_top;
   localparam int AW = 20;
   localparam int SPAN = AW - 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n;
   logic [7:0]        cfg_wide, cfg_three;
   logic [15:0]       cfg_wait;
   logic              cfg_pin_wait_en, cfg_idle_en;
   logic              req, req_wr, req_word;
   logic [AW-1:0]     req_addr;
   logic [15:0]       req_wdata;
   logic              ready, done;
   logic [15:0]       rdata;
   logic [AW-1:0]     bus_addr;
   logic [7:0]        cs_n;
   logic              as_n, rd_n, hwr_n, lwr_n, bus_oe;
   logic [15:0]       bus_dout, bus_din;
   logic              wait_n;

   function automatic logic [7:0] pat_hi(logic [AW-1:0] a);
      return a[7:0] ^ 8'hA5;
   endfunction
   function automatic logic [7:0] pat_lo(logic [AW-1:0] a);
      return a[7:0] ^ 8'h3C;
   endfunction

   assign bus_din = {pat_hi(bus_addr), pat_lo(bus_addr)};

   ebc_bus_ctrl #(.ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_three(cfg_three),
      .cfg_wait(cfg_wait), .cfg_pin_wait_en(cfg_pin_wait_en),
      .cfg_idle_en(cfg_idle_en), .req(req), .req_wr(req_wr),
      .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
      .ready(ready), .done(done), .rdata(rdata), .bus_addr(bus_addr),
      .cs_n(cs_n), .as_n(as_n), .rd_n(rd_n), .hwr_n(hwr_n), .lwr_n(lwr_n),
      .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din),
      .wait_n(wait_n)
   );

   typedef struct packed {
      logic          gap;
      logic [7:0]    cs_n;
      logic          as_n, rd_n, hwr_n, lwr_n, oe;
      logic [AW-1:0] addr;
      logic [15:0]   dout;
      logic          wlow;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   prev_rd = 1'b0;
   int   prev_area = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic push_cycle(input int area, input logic [AW-1:0] a, input bit wr,
                             input bit up, input bit lo, input logic [15:0] dv,
                             input int k);
      bit three = cfg_three[area];
      int n     = three ? int'(cfg_wait[2*area +: 2]) : 0;
      int extra = (three && cfg_pin_wait_en) ? k : 0;
      int len   = three ? 3 + n + extra : 2;
      for (int i = 0; i < len; i++) begin
         exp_t e;
         e.gap   = 1'b0;
         e.cs_n  = 8'hFF;
         e.cs_n[area] = 1'b0;
         e.as_n  = 1'b0;
         e.rd_n  = wr;
         e.hwr_n = !(wr && up && i > 0);
         e.lwr_n = !(wr && lo && i > 0);
         e.oe    = wr;
         e.addr  = a;
         e.dout  = dv;
         e.wlow  = (k > 0) && (i >= 1 + n) && (i <= n + k);
         q.push_back(e);
      end
   endtask

   // issued at a falling edge while ready is high; returns at the falling edge showing done
   task automatic txn(input string tag, input int area, input int off, input bit wr,
                      input bit word, input logic [15:0] wd, input int k);
      logic [AW-1:0] a = AW'((area << SPAN) | off);
      logic [AW-1:0] ae = {a[AW-1:1], 1'b0};
      logic [15:0]   exp_rd;
      bit wide = cfg_wide[area];
      if (cfg_idle_en && prev_rd && (wr || area != prev_area)) begin
         exp_t g;
         g = '0;
         g.gap = 1'b1; g.cs_n = 8'hFF; g.as_n = 1'b1; g.rd_n = 1'b1;
         g.hwr_n = 1'b1; g.lwr_n = 1'b1;
         q.push_back(g);
      end
      if (word && !wide) begin
         push_cycle(area, ae, wr, 1'b1, 1'b0, {wd[15:8], wd[15:8]}, k);
         push_cycle(area, ae | 1, wr, 1'b1, 1'b0, {wd[7:0], wd[7:0]}, k);
         exp_rd = {pat_hi(ae), pat_hi(ae | 1)};
      end else if (word) begin
         push_cycle(area, ae, wr, 1'b1, 1'b1, wd, k);
         exp_rd = {pat_hi(ae), pat_lo(ae)};
      end else begin
         bit up = !wide || !a[0];
         bit lo = wide && a[0];
         push_cycle(area, a, wr, up, lo, {wd[7:0], wd[7:0]}, k);
         exp_rd = {8'h00, up ? pat_hi(a) : pat_lo(a)};
      end
      req = 1'b1; req_wr = wr; req_word = word; req_addr = a; req_wdata = wd;
      while (q.size() > 0) begin
         exp_t e;
         @(negedge clk);
         req = 1'b0;
         e = q.pop_front();
         wait_n = !e.wlow;
         chk(cs_n == e.cs_n, "R1", "cs_n", 32'(cs_n), 32'(e.cs_n));
         chk(as_n == e.as_n, tag, "as_n (cycle length)", 32'(as_n), 32'(e.as_n));
         chk(rd_n == e.rd_n, "R7", "rd_n", 32'(rd_n), 32'(e.rd_n));
         chk({hwr_n, lwr_n} == {e.hwr_n, e.lwr_n}, tag, "hwr_n/lwr_n",
             32'({hwr_n, lwr_n}), 32'({e.hwr_n, e.lwr_n}));
         chk(bus_oe == e.oe, "R7", "bus_oe", 32'(bus_oe), 32'(e.oe));
         chk(!ready, "R9", "ready during access", 32'(ready), 32'd0);
         if (!e.gap)
            chk(bus_addr == e.addr, "R1", "bus_addr", 32'(bus_addr), 32'(e.addr));
         if (e.oe)
            chk(bus_dout == e.dout, tag, "bus_dout", 32'(bus_dout), 32'(e.dout));
      end
      @(negedge clk);
      wait_n = 1'b1;
      chk(done && ready, "R9", "done/ready after last state", 32'({done, ready}), 32'h3);
      chk(as_n && (cs_n == 8'hFF), tag, "access ended", 32'({as_n, cs_n}), 32'h1FF);
      if (!wr)
         chk(rdata == exp_rd, tag, "rdata", 32'(rdata), 32'(exp_rd));
      prev_rd   = !wr;
      prev_area = area;
   endtask

   initial begin
      #(8 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      req = 1'b0; req_wr = 1'b0; req_word = 1'b0; req_addr = '0; req_wdata = '0;
      wait_n = 1'b1;
      cfg_wide  = 8'b0101_0011;
      cfg_three = 8'b1111_0110;
      cfg_wait  = 16'hC7CB;
      cfg_pin_wait_en = 1'b0;
      cfg_idle_en     = 1'b0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(ready && !done, "R10", "ready/done in reset", 32'({ready, done}), 32'h2);
      chk(cs_n == 8'hFF, "R10", "cs_n in reset", 32'(cs_n), 32'hFF);
      chk({as_n, rd_n, hwr_n, lwr_n, bus_oe} == 5'b11110, "R10", "strobes in reset",
          32'({as_n, rd_n, hwr_n, lwr_n, bus_oe}), 32'h1E);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready && !done && as_n, "R10", "idle after reset", 32'({ready, done, as_n}), 32'h5);

      txn("R2", 0, 'h0010, 1'b1, 1'b0, 16'h005A, 2);   // 2-state, programmed waits ignored
      txn("R3", 1, 'h0120, 1'b0, 1'b1, 16'h0000, 0);   // 3-state, 2 waits, word read
      txn("R5", 1, 'h0033, 1'b1, 1'b0, 16'h00C3, 0);   // odd byte, lower lane
      txn("R5", 4, 'h0044, 1'b0, 1'b0, 16'h0000, 0);   // even byte read, upper lane
      txn("R6", 2, 'h0056, 1'b1, 1'b1, 16'hBEEF, 0);   // word split in 8-bit area
      txn("R6", 5, 'h0078, 1'b0, 1'b1, 16'h0000, 0);   // split word read
      txn("R9", 3, 'h0091, 1'b0, 1'b0, 16'h0000, 0);   // 8-bit odd byte read
      txn("R4", 6, 'h0100, 1'b0, 1'b1, 16'h0000, 2);   // pin disabled: wait_n ignored
      cfg_pin_wait_en = 1'b1;
      txn("R4", 6, 'h0200, 1'b0, 1'b1, 16'h0000, 3);   // N=0, three pin waits
      txn("R4", 7, 'h0301, 1'b1, 1'b0, 16'h0077, 2);   // N=3 then two pin waits
      txn("R2", 0, 'h0402, 1'b0, 1'b0, 16'h0000, 2);   // 2-state ignores pin
      cfg_idle_en = 1'b1;
      txn("R8", 1, 'h0500, 1'b0, 1'b0, 16'h0000, 0);   // read after read, other area
      txn("R8", 1, 'h0502, 1'b0, 1'b1, 16'h0000, 0);   // same area: no gap
      txn("R8", 4, 'h0600, 1'b1, 1'b1, 16'h1234, 0);   // write after read: gap
      txn("R8", 2, 'h0700, 1'b0, 1'b0, 16'h0000, 0);   // read after write: no gap
      cfg_idle_en = 1'b0;
      txn("R8", 3, 'h0800, 1'b0, 1'b0, 16'h0000, 0);   // disabled: no gap
      txn("R7", 6, 'h0900, 1'b1, 1'b1, 16'hA55A, 1);   // word write, both strobes
      txn("R5", 0, 'h0A00, 1'b1, 1'b1, 16'h9876, 0);   // word write 2-state, both lanes

      @(negedge clk);
      chk(!done && ready, "R9", "done is one pulse", 32'({done, ready}), 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule